// File: doc/BRIEF.md
# Masked Vector Element Executor

This block carries out one element-wise vector operation at a time under a per-element mask. Two source vectors of `N` elements sit on wide parallel ports and are held steady by the surrounding pipeline while a command runs. Three mask commands act only on the mask register, which holds one bit per element. "Nonzero test" sets bit i when element i of A is not zero. "Signed greater-or-equal" sets bit i when A[i] >= B[i]. "Invert" flips every bit that is below the vector length. Three execute commands send a result to the destination write port, and only for elements whose mask bit is set: copy A, copy B, or the sum A+B. A copy of A under the mask, followed by an invert and a copy of B, gives an element-wise select of the larger value into the destination.

Each execute command runs in one of two modes. Gated mode walks every element below the vector length, one per cycle, and holds the write enable low where the mask bit is clear. Packed mode scans the mask with a priority encoder and spends one cycle on each enabled element only, so a sparse mask finishes early. In both modes elements are handled in increasing index order. Only elements below the vector length take part. A length above `N` counts as `N`.

Top module: `mvx_masked_exec`

## Requirements
- R1: Command code 0 (nonzero test) sets mask bit i to (A[i] != 0) for every i below the effective length and clears every bit at or above it. It stays busy for exactly one cycle, and the new mask is visible after that cycle.
- R2: Command code 1 (signed greater-or-equal) sets mask bit i to (A[i] >= B[i]), comparing the elements as two's-complement values, for i below the effective length. It clears the bits above the length and takes one busy cycle.
- R3: Command code 2 (invert) replaces every mask bit below the effective length with its complement and clears the bits above it. It takes one busy cycle.
- R4: In gated mode (dense input 0), an execute command is busy for max(L,1) cycles, where L is the effective length. Busy cycle k presents element k, and the write enable equals mask bit k. The mask does not change while the command runs.
- R5: In packed mode (dense input 1), an execute command is busy for max(P,1) cycles, where P is the number of set mask bits below the effective length. Every busy cycle with a hit writes the next set element in increasing index order. A mask with no set bits finishes in a single cycle and writes nothing.
- R6: The write data for element i is A[i] for code 3, B[i] for code 4, and (A[i]+B[i]) mod 2^DATA_W for code 5.
- R7: The effective length is min(length input, N), captured when the command is accepted. Elements at or above it are never written, even when their mask bits are set.
- R8: A command is accepted only while busy is low and the code is 0 to 5. A command offered while busy is high, or with code 6 or 7, has no effect on the mask, the write port or the length of the running command.
- R9: Done is high in exactly the last busy cycle of every command, and busy is low in the cycle after.
- R10: After reset, busy, done and the write enable are low and the mask is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 3 | Command code 0 to 5 |
| cmdDense | input | 1 | 1 selects packed mode for execute commands |
| cmdLen | input | $clog2(N+1) | Vector length for the command |
| vecA | input | N*DATA_W | Source vector A, element i at bits [i*DATA_W +: DATA_W] |
| vecB | input | N*DATA_W | Source vector B, same layout |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Last cycle of the current command |
| maskOut | output | N | Mask register, bit i for element i |
| wrEn | output | 1 | Destination write strobe |
| wrIdx | output | $clog2(N) | Destination element index |
| wrData | output | DATA_W | Destination element value |

## Verification
The assertions check on every cycle the properties that hold whatever the data is. A write only happens while busy, and only to an element whose mask bit is set. Write indices rise within a command. Done falls in a busy cycle and is followed by idle. An accepted command raises busy, and the mask stays still during execute commands. Only the bench scenarios can show the values: the mask each compare produces from chosen signed data, the exact busy length in each mode (including a zero mask, a zero length and an oversized length), the write data for each execute command, and the select built from copy, invert and copy.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

  typedef enum logic [2:0] {
    OP_CMP_NZ   = 3'd0,
    OP_CMP_GE   = 3'd1,
    OP_MASK_INV = 3'd2,
    OP_SEL_A    = 3'd3,
    OP_SEL_B    = 3'd4,
    OP_ADD      = 3'd5
  } vecOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setNz;
    logic setGe;
    logic invert;
    logic armScan;
    logic retire;
  } ctlStrobe_t;

endpackage

// File: rtl/mvx_ctl.sv
module mvx_ctl
  import mvx_pkg::*;
#(
  parameter int N      = 8,
  parameter int IDX_W  = $clog2(N),
  parameter int LEN_W  = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdDense,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [N-1:0]     maskQ,
  input  logic             scanHit,
  input  logic [IDX_W-1:0] scanIdx,
  input  logic             scanLast,
  output ctlStrobe_t       strobe,
  output logic [LEN_W-1:0] vlenArm,
  output logic [LEN_W-1:0] vlenQ,
  output vecOp_e           opQ,
  output logic             busy,
  output logic             done,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrIdx
);

  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(N);

  logic             busyQ;
  logic             denseQ;
  logic [LEN_W-1:0] cntQ;
  logic             accept;
  logic             isMaskOp;

  assign vlenArm  = (cmdLen > MaxLen) ? MaxLen : cmdLen;
  assign accept   = cmdValid && !busyQ && (cmdOp <= 3'd5);
  assign isMaskOp = (opQ == OP_CMP_NZ) || (opQ == OP_CMP_GE) || (opQ == OP_MASK_INV);
  assign busy     = busyQ;

  always_comb begin
    strobe         = '0;
    strobe.armScan = accept;
    wrEn           = 1'b0;
    wrIdx          = '0;
    done           = 1'b0;
    if (busyQ) begin
      if (isMaskOp) begin
        strobe.setNz  = (opQ == OP_CMP_NZ);
        strobe.setGe  = (opQ == OP_CMP_GE);
        strobe.invert = (opQ == OP_MASK_INV);
        done          = 1'b1;
      end else if (denseQ) begin
        wrEn          = scanHit;
        wrIdx         = scanIdx;
        strobe.retire = scanHit;
        done          = !scanHit || scanLast;
      end else begin
        wrIdx = cntQ[IDX_W-1:0];
        wrEn  = (cntQ < vlenQ) && maskQ[cntQ[IDX_W-1:0]];
        done  = ((cntQ + LEN_W'(1)) >= vlenQ);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      denseQ <= 1'b0;
      vlenQ  <= '0;
      cntQ   <= '0;
      opQ    <= OP_CMP_NZ;
    end else if (accept) begin
      busyQ  <= 1'b1;
      denseQ <= cmdDense;
      vlenQ  <= vlenArm;
      cntQ   <= '0;
      opQ    <= vecOp_e'(cmdOp);
    end else if (busyQ) begin
      cntQ <= cntQ + LEN_W'(1);
      if (done) busyQ <= 1'b0;
    end
  end

endmodule

// File: rtl/mvx_dp.sv
module mvx_dp
  import mvx_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(N),
  parameter int LEN_W  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [LEN_W-1:0]  vlenArm,
  input  logic [LEN_W-1:0]  vlenQ,
  input  vecOp_e            opQ,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [N*DATA_W-1:0] vecA,
  input  logic [N*DATA_W-1:0] vecB,
  output logic [N-1:0]      maskQ,
  output logic              scanHit,
  output logic [IDX_W-1:0]  scanIdx,
  output logic              scanLast,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] elemA [N];
  logic [DATA_W-1:0] elemB [N];
  logic [N-1:0]      cmpNz;
  logic [N-1:0]      cmpGe;
  logic [N-1:0]      pendQ;
  logic [N-1:0]      lowBit;
  logic [N-1:0]      runLen;
  logic [N-1:0]      armLen;

  function automatic logic [N-1:0] lenMask(input logic [LEN_W-1:0] len);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (LEN_W'(i) < len);
    return m;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_elem
    assign elemA[g] = vecA[g*DATA_W +: DATA_W];
    assign elemB[g] = vecB[g*DATA_W +: DATA_W];
    assign cmpNz[g] = |elemA[g];
    assign cmpGe[g] = $signed(elemA[g]) >= $signed(elemB[g]);
  end

  assign runLen = lenMask(vlenQ);
  assign armLen = lenMask(vlenArm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.setNz) begin
      maskQ <= cmpNz & runLen;
    end else if (strobe.setGe) begin
      maskQ <= cmpGe & runLen;
    end else if (strobe.invert) begin
      maskQ <= ~maskQ & runLen;
    end
  end

  // lowest pending bit, isolated
  assign lowBit   = pendQ & (~pendQ + N'(1));
  assign scanLast = ((pendQ & ~lowBit) == '0);

  always_comb begin
    scanHit = 1'b0;
    scanIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        scanHit = 1'b1;
        scanIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else if (strobe.armScan) begin
      pendQ <= maskQ & armLen;
    end else if (strobe.retire) begin
      pendQ <= pendQ & ~lowBit;
    end
  end

  always_comb begin
    case (opQ)
      OP_SEL_B: wrData = elemB[wrIdx];
      OP_ADD:   wrData = elemA[wrIdx] + elemB[wrIdx];
      default:  wrData = elemA[wrIdx];
    endcase
  end

endmodule

// File: rtl/mvx_masked_exec.sv
module mvx_masked_exec
  import mvx_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N),
  localparam int LEN_W = $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic                cmdDense,
  input  logic [LEN_W-1:0]    cmdLen,
  input  logic [N*DATA_W-1:0] vecA,
  input  logic [N*DATA_W-1:0] vecB,
  output logic                busy,
  output logic                done,
  output logic [N-1:0]        maskOut,
  output logic                wrEn,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [DATA_W-1:0]   wrData
);

  ctlStrobe_t       strobe;
  logic [LEN_W-1:0] vlenArm;
  logic [LEN_W-1:0] vlenQ;
  vecOp_e           opQ;
  logic             scanHit;
  logic [IDX_W-1:0] scanIdx;
  logic             scanLast;

  mvx_ctl #(.N(N), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdDense(cmdDense), .cmdLen(cmdLen), .maskQ(maskOut),
    .scanHit(scanHit), .scanIdx(scanIdx), .scanLast(scanLast),
    .strobe(strobe), .vlenArm(vlenArm), .vlenQ(vlenQ), .opQ(opQ),
    .busy(busy), .done(done), .wrEn(wrEn), .wrIdx(wrIdx)
  );

  mvx_dp #(.N(N), .DATA_W(DATA_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vlenArm(vlenArm),
    .vlenQ(vlenQ), .opQ(opQ), .wrIdx(wrIdx), .vecA(vecA), .vecB(vecB),
    .maskQ(maskOut), .scanHit(scanHit), .scanIdx(scanIdx),
    .scanLast(scanLast), .wrData(wrData)
  );

endmodule

// File: rtl/mvx_chk.sv
module mvx_chk #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic             busy,
  input logic             done,
  input logic [N-1:0]     maskOut,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx
);

  logic             seenQ;
  logic [IDX_W-1:0] lastIdxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenQ    <= 1'b0;
      lastIdxQ <= '0;
    end else if (!busy || done) begin
      seenQ <= 1'b0;
    end else if (wrEn) begin
      seenQ    <= 1'b1;
      lastIdxQ <= wrIdx;
    end
  end

  assert_write_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);
  assert_write_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> maskOut[wrIdx]);
  assert_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && seenQ) |-> (wrIdx > lastIdxQ));
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp <= 3'd5) |=> busy);
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(maskOut));

endmodule

bind mvx_masked_exec mvx_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .busy(busy), .done(done), .maskOut(maskOut), .wrEn(wrEn), .wrIdx(wrIdx)
);

// File: tb/tb_mvx_masked_exec.sv
module tb_mvx_masked_exec;

  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [2:0]      cmdOp = 3'd0;
  logic            cmdDense = 1'b0;
  logic [3:0]      cmdLen = 4'd0;
  logic [N*DW-1:0] vecA;
  logic [N*DW-1:0] vecB;
  logic            busy, done, wrEn;
  logic [N-1:0]    maskOut;
  logic [2:0]      wrIdx;
  logic [DW-1:0]   wrData;

  logic [DW-1:0] aE [N];
  logic [DW-1:0] bE [N];
  logic [N-1:0]  expMask = '0;
  int expIdxQ[$];
  int expDatQ[$];
  int nTests = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      vecA[i*DW +: DW] = aE[i];
      vecB[i*DW +: DW] = bE[i];
    end
  end

  mvx_masked_exec #(.N(N), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdDense(cmdDense), .cmdLen(cmdLen), .vecA(vecA), .vecB(vecB),
    .busy(busy), .done(done), .maskOut(maskOut), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write must match the head of the queue
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (expIdxQ.size() == 0) begin
        chk(1'b0, "R7 unexpected write", int'(wrIdx), -1);
      end else begin
        int ei, ed;
        ei = expIdxQ.pop_front();
        ed = expDatQ.pop_front();
        chk(int'(wrIdx) == ei, "R5 write index", int'(wrIdx), ei);
        chk(int'(wrData) == ed, "R6 write data", int'(wrData), ed);
      end
    end
  end

  // driver: computes expectations, issues command, measures busy length
  task automatic runCmd(input int op, input bit dense, input int len, input bit poke, input string req);
    int effLen, expCyc, cnt, cyc;
    logic [N-1:0] newMask;
    bit doneSeen;
    effLen = (len > N) ? N : len;
    newMask = expMask;
    cnt = 0;
    if (op <= 2) begin
      expCyc = 1;
      for (int i = 0; i < N; i++) begin
        if (i >= effLen) newMask[i] = 1'b0;
        else if (op == 0) newMask[i] = (aE[i] != 0);
        else if (op == 1) newMask[i] = ($signed(aE[i]) >= $signed(bE[i]));
        else newMask[i] = ~expMask[i];
      end
    end else begin
      for (int i = 0; i < effLen; i++) begin
        if (expMask[i]) begin
          cnt++;
          expIdxQ.push_back(i);
          if (op == 3) expDatQ.push_back(int'(aE[i]));
          else if (op == 4) expDatQ.push_back(int'(bE[i]));
          else expDatQ.push_back(int'(DW'(aE[i] + bE[i])));
        end
      end
      if (dense) expCyc = (cnt > 0) ? cnt : 1;
      else expCyc = (effLen > 0) ? effLen : 1;
    end
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdDense = dense; cmdLen = 4'(len);
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 0;
    doneSeen = 1'b0;
    for (int k = 0; k < 40 && !doneSeen; k++) begin
      if (busy) cyc++;
      if (done) doneSeen = 1'b1;
      else begin
        if (poke && cyc == 2) begin
          cmdValid = 1'b1; cmdOp = 3'd2; cmdLen = 4'd8;
        end
        @(negedge clk);
        cmdValid = 1'b0;
      end
    end
    chk(doneSeen, {req, " done seen"}, int'(doneSeen), 1);
    chk(cyc == expCyc, {req, " busy cycles"}, cyc, expCyc);
    @(negedge clk);
    chk(!busy, "R9 idle after done", int'(busy), 0);
    chk(expIdxQ.size() == 0, {req, " writes pending"}, expIdxQ.size(), 0);
    expIdxQ.delete();
    expDatQ.delete();
    expMask = newMask;
    chk(maskOut == expMask, {req, " mask"}, int'(maskOut), int'(expMask));
  endtask

  initial begin
    #(CLK_P * 150000);
    nFail++;
    $display("FAIL R9 watchdog expired act=hung exp=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin aE[i] = '0; bE[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !wrEn, "R10 reset outputs", {busy, done, wrEn}, 0);
    chk(maskOut == '0, "R10 reset mask", int'(maskOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // mask 0,1,0,0,1,1,0,1 -> writes to 1,4,5,7
    aE = '{16'd0, 16'd11, 16'd0, 16'd0, 16'd44, 16'd55, 16'd0, 16'd77};
    bE = '{16'd5, 16'd3, 16'hFFFE, 16'd9, 16'd44, 16'hFFF0, 16'd1, 16'd100};
    runCmd(0, 1'b0, 8, 1'b0, "R1");
    chk(maskOut == 8'b1011_0010, "R1 example mask", int'(maskOut), 8'hB2);
    runCmd(3, 1'b0, 8, 1'b0, "R4");
    runCmd(3, 1'b1, 8, 1'b0, "R5");
    runCmd(5, 1'b0, 5, 1'b0, "R7");
    runCmd(5, 1'b1, 5, 1'b0, "R7");

    // signed compare and select via copy, invert, copy
    aE = '{16'hFFFF, 16'd2, 16'd3, 16'h8000, 16'd0, 16'd7, 16'hFFF8, 16'd6};
    bE = '{16'd1, 16'd2, 16'd2, 16'd0, 16'hFFFD, 16'd8, 16'hFFF7, 16'd5};
    runCmd(1, 1'b0, 8, 1'b0, "R2");
    runCmd(3, 1'b1, 8, 1'b0, "R5");
    runCmd(2, 1'b0, 8, 1'b0, "R3");
    runCmd(4, 1'b1, 8, 1'b0, "R6");
    runCmd(5, 1'b0, 8, 1'b0, "R6");

    // short length compare and oversized length
    runCmd(1, 1'b0, 3, 1'b0, "R2");
    runCmd(2, 1'b0, 12, 1'b0, "R7");
    runCmd(4, 1'b0, 12, 1'b0, "R7");

    // command offered while busy is ignored
    runCmd(3, 1'b0, 8, 1'b1, "R8");

    // invalid command code ignored
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd7; cmdLen = 4'd8;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(!busy, "R8 code 7 ignored", int'(busy), 0);
    @(negedge clk);
    chk(maskOut == expMask, "R8 mask kept", int'(maskOut), int'(expMask));

    // zero mask: packed one cycle, gated full length; zero length
    for (int i = 0; i < N; i++) aE[i] = '0;
    runCmd(0, 1'b0, 8, 1'b0, "R1");
    runCmd(3, 1'b1, 8, 1'b0, "R5");
    runCmd(3, 1'b0, 6, 1'b0, "R4");
    runCmd(2, 1'b0, 8, 1'b0, "R3");
    runCmd(5, 1'b0, 0, 1'b0, "R4");
    runCmd(5, 1'b1, 0, 1'b0, "R5");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule